// File: doc/BRIEF.md
# Tone, Time-Base and Watchdog Unit

This block is a divider-based peripheral that runs directly on the system clock, which is nominally 256 kHz. A single prescaler counts active clock cycles. Several features are drawn from that count:

- a complementary buzzer tone pair at one of two pitches;
- a time-base flag that a chosen prescaler tap sets;
- a four-tick watchdog, clocked from its own chosen tap.

Either of the two flags can pull down one shared, active-low interrupt request. The line behaves like an open-drain output and is released when nothing is pending.

The host drives the block through a one-cycle command port. Each command is an opcode strobe with a small argument field. The commands switch the tone on and off, pick the pitch, select the sources, enable or disable the timers, clear the watchdog, gate the request output and put the unit into or out of power-down. A system-level state machine has two states, `SYS_ACTIVE` and `SYS_SLEEP`. The sleep command moves it to `SYS_SLEEP` and the wake command moves it back to `SYS_ACTIVE`. The watchdog has its own state machine with three states, `WD_STOP`, `WD_COUNT` and `WD_OVER`, and these transitions:

- enable: `WD_STOP` to `WD_COUNT`;
- last tick: `WD_COUNT` to `WD_OVER`;
- clear: `WD_OVER` to `WD_COUNT`;
- disable: any state to `WD_STOP`.

Top module: `tone_timer_unit`

## Requirements
- R1: After reset the unit is active, the tone is off at the low pitch, both timers and the request gate are disabled, both tap selects are 0, the prescaler count is 0, both tone outputs are low and `irq_n_o` is high.
- R2: While the tone is off both tone outputs are low. While it is on and the unit is active, `tone_n_o` is always the complement of `tone_p_o`.
- R3: The active-cycle count starts at 0 after reset. At the low pitch (system clock / 128), `tone_p_o` equals bit 6 of that count. At the high pitch (system clock / 64), it equals bit 5.
- R4: Tap k (k = 0..7, chosen by the 3-bit argument) fires on each active cycle in which the count plus one is a multiple of 2^(8+k). While the time base is enabled, a firing of its tap sets the time-base flag on that clock edge.
- R5: Once enabled, the watchdog overflows on the fourth firing of its tap and then stays overflowed.
- R6: A watchdog clear zeroes the watchdog count, returns an overflowed watchdog to counting and clears the time-base flag. A tap firing in the same cycle as a clear is discarded.
- R7: `irq_n_o` is low exactly when the request gate is enabled and either the time-base flag is set or the watchdog has overflowed. It goes high on the cycle after a request-off command.
- R8: In power-down the prescaler count, the watchdog count and both flags hold their values, no tap fires and both tone outputs are low. After wake, counting resumes from the held values.
- R9: Opcodes on `cmd_op_i`, sampled on the clock edge where `cmd_valid_i` is high:
  - 0: no operation
  - 1: sleep
  - 2: wake
  - 3: tone off
  - 4: tone on
  - 5: low pitch
  - 6: high pitch
  - 7: time-base tap = arg
  - 8: watchdog tap = arg
  - 9: time base on
  - 10: time base off
  - 11: watchdog on
  - 12: watchdog off
  - 13: watchdog clear
  - 14: request on
  - 15: request off
- R10: The time-base off command clears the time-base flag and stops it from being set. The watchdog off command returns the watchdog to stopped with a zero count and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command opcode |
| cmd_arg_i | input | 3 | Tap index for the two source-select commands |
| tone_p_o | output | 1 | Tone output, true phase |
| tone_n_o | output | 1 | Tone output, inverted phase |
| irq_n_o | output | 1 | Active-low request; high means released |

## Verification
The watchdog clear and a firing of the watchdog's tap can land on the same clock edge. The bench provokes this by watching its own active-cycle count and issuing the clear in the exact cycle where the low byte is all ones. The result is judged from the request output. It must stay released for three more tap periods and fall only after the fourth, whereas a design that counted the coincident tick would raise the request one period early. A sleep command that arrives while the watchdog is counting is judged the same way: the request must stay released through a long sleep and must appear only after wake.

// File: rtl/ttu_pkg.sv
package ttu_pkg;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_SLEEP     = 4'd1,
        OP_WAKE      = 4'd2,
        OP_TONE_OFF  = 4'd3,
        OP_TONE_ON   = 4'd4,
        OP_TONE_LOW  = 4'd5,
        OP_TONE_HIGH = 4'd6,
        OP_TB_SRC    = 4'd7,
        OP_WD_SRC    = 4'd8,
        OP_TB_ON     = 4'd9,
        OP_TB_OFF    = 4'd10,
        OP_WD_ON     = 4'd11,
        OP_WD_OFF    = 4'd12,
        OP_WD_CLR    = 4'd13,
        OP_IRQ_ON    = 4'd14,
        OP_IRQ_OFF   = 4'd15
    } cmd_op_e;

    typedef enum logic {
        SYS_ACTIVE = 1'b0,
        SYS_SLEEP  = 1'b1
    } sys_state_e;

    typedef enum logic [1:0] {
        WD_STOP  = 2'd0,
        WD_COUNT = 2'd1,
        WD_OVER  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/ttu_ctrl.sv
module ttu_ctrl
    import ttu_pkg::*;
#(
    parameter int N_TAPS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid_i,
    input  logic [3:0]                cmd_op_i,
    input  logic [$clog2(N_TAPS)-1:0] cmd_arg_i,
    output logic                      run_o,
    output logic                      tone_en_o,
    output logic                      tone_hi_o,
    output logic [$clog2(N_TAPS)-1:0] tb_src_o,
    output logic [$clog2(N_TAPS)-1:0] wd_src_o,
    output logic                      tb_en_o,
    output logic                      tb_off_o,
    output logic                      wd_on_o,
    output logic                      wd_off_o,
    output logic                      wd_clr_o,
    output logic                      irq_en_o
);

    localparam int SRC_W = $clog2(N_TAPS);

    cmd_op_e    op;
    sys_state_e state_q, state_d;

    assign op = cmd_op_e'(cmd_op_i);

    // System state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SYS_ACTIVE;
        else        state_q <= state_d;
    end

    // System next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYS_ACTIVE: if (cmd_valid_i && op == OP_SLEEP) state_d = SYS_SLEEP;
            SYS_SLEEP:  if (cmd_valid_i && op == OP_WAKE)  state_d = SYS_ACTIVE;
            default:    state_d = SYS_ACTIVE;
        endcase
    end

    // System outputs
    always_comb begin
        run_o = (state_q == SYS_ACTIVE);
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tone_en_o <= 1'b0;
            tone_hi_o <= 1'b0;
            tb_src_o  <= '0;
            wd_src_o  <= '0;
            tb_en_o   <= 1'b0;
            irq_en_o  <= 1'b0;
        end else if (cmd_valid_i) begin
            case (op)
                OP_TONE_OFF:  tone_en_o <= 1'b0;
                OP_TONE_ON:   tone_en_o <= 1'b1;
                OP_TONE_LOW:  tone_hi_o <= 1'b0;
                OP_TONE_HIGH: tone_hi_o <= 1'b1;
                OP_TB_SRC:    tb_src_o  <= SRC_W'(cmd_arg_i);
                OP_WD_SRC:    wd_src_o  <= SRC_W'(cmd_arg_i);
                OP_TB_ON:     tb_en_o   <= 1'b1;
                OP_TB_OFF:    tb_en_o   <= 1'b0;
                OP_IRQ_ON:    irq_en_o  <= 1'b1;
                OP_IRQ_OFF:   irq_en_o  <= 1'b0;
                default: ;
            endcase
        end
    end

    // One-cycle strobes toward the timers
    assign tb_off_o = cmd_valid_i && (op == OP_TB_OFF);
    assign wd_on_o  = cmd_valid_i && (op == OP_WD_ON);
    assign wd_off_o = cmd_valid_i && (op == OP_WD_OFF);
    assign wd_clr_o = cmd_valid_i && (op == OP_WD_CLR);

    assert_sleep_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_SLEEP) |=> !run_o);

    assert_wake_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_WAKE) |=> run_o);

endmodule

// File: rtl/ttu_prescaler.sv
module ttu_prescaler #(
    parameter int TAP_BASE    = 8,
    parameter int N_TAPS      = 8,
    parameter int TONE_LO_BIT = 6,
    parameter int TONE_HI_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [N_TAPS-1:0] tick_o,
    output logic              lo_phase_o,
    output logic              hi_phase_o
);

    localparam int PRE_W = TAP_BASE + N_TAPS - 1;

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;
    end

    // Tap k fires when the low TAP_BASE+k bits are all ones
    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        assign tick_o[k] = run_i & (&cnt_q[TAP_BASE+k-1:0]);
    end

    assign lo_phase_o = cnt_q[TONE_LO_BIT];
    assign hi_phase_o = cnt_q[TONE_HI_BIT];

    assert_hold_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cnt_q));

    assert_count_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> (cnt_q == PRE_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/ttu_watchdog.sv
module ttu_watchdog
    import ttu_pkg::*;
#(
    parameter int N_TAPS   = 8,
    parameter int WD_TICKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TAPS-1:0]         tick_i,
    input  logic [$clog2(N_TAPS)-1:0] src_i,
    input  logic                      on_i,
    input  logic                      off_i,
    input  logic                      clr_i,
    output logic                      over_o
);

    localparam int              CNT_W = $clog2(WD_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_TICKS - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sel_tick;

    assign sel_tick = tick_i[src_i];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: disable beats all, clear beats a tick
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (off_i) begin
            state_d = WD_STOP;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                WD_STOP: begin
                    if (on_i) begin
                        state_d = WD_COUNT;
                        cnt_d   = '0;
                    end
                end
                WD_COUNT: begin
                    if (clr_i) begin
                        cnt_d = '0;
                    end else if (sel_tick) begin
                        if (cnt_q == LAST) state_d = WD_OVER;
                        else               cnt_d   = cnt_q + 1'b1;
                    end
                end
                WD_OVER: begin
                    if (clr_i) begin
                        state_d = WD_COUNT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = WD_STOP;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        over_o = (state_q == WD_OVER);
    end

    assert_fourth_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_COUNT && cnt_q == LAST && sel_tick && !clr_i && !off_i)
        |=> (state_q == WD_OVER));

    assert_stays_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_OVER && !clr_i && !off_i) |=> (state_q == WD_OVER));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !off_i && state_q != WD_STOP) |=> (cnt_q == '0 && state_q == WD_COUNT));

    assert_off_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> (state_q == WD_STOP && cnt_q == '0));

endmodule

// File: rtl/ttu_tone_out.sv
module ttu_tone_out (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic en_i,
    input  logic hi_i,
    input  logic lo_phase_i,
    input  logic hi_phase_i,
    output logic tone_p_o,
    output logic tone_n_o
);

    logic gate;
    logic phase;

    assign gate  = run_i & en_i;
    assign phase = hi_i ? hi_phase_i : lo_phase_i;

    always_comb begin
        tone_p_o = gate &  phase;
        tone_n_o = gate & ~phase;
    end

    assert_never_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_p_o && tone_n_o));

    assert_low_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (!tone_p_o && !tone_n_o));

endmodule

// File: rtl/tone_timer_unit.sv
module tone_timer_unit
    import ttu_pkg::*;
#(
    parameter int TAP_BASE    = 8,
    parameter int N_TAPS      = 8,
    parameter int TONE_LO_BIT = 6,
    parameter int TONE_HI_BIT = 5,
    parameter int WD_TICKS    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid_i,
    input  logic [3:0]                cmd_op_i,
    input  logic [$clog2(N_TAPS)-1:0] cmd_arg_i,
    output logic                      tone_p_o,
    output logic                      tone_n_o,
    output logic                      irq_n_o
);

    localparam int SRC_W = $clog2(N_TAPS);

    logic              run, tone_en, tone_hi, tb_en, tb_off, wd_on, wd_off, wd_clr, irq_en;
    logic [SRC_W-1:0]  tb_src, wd_src;
    logic [N_TAPS-1:0] tick;
    logic              lo_phase, hi_phase, wd_over, tb_flag_q;

    ttu_ctrl #(.N_TAPS(N_TAPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i),
        .run_o(run), .tone_en_o(tone_en), .tone_hi_o(tone_hi),
        .tb_src_o(tb_src), .wd_src_o(wd_src), .tb_en_o(tb_en), .tb_off_o(tb_off),
        .wd_on_o(wd_on), .wd_off_o(wd_off), .wd_clr_o(wd_clr), .irq_en_o(irq_en)
    );

    ttu_prescaler #(
        .TAP_BASE(TAP_BASE), .N_TAPS(N_TAPS),
        .TONE_LO_BIT(TONE_LO_BIT), .TONE_HI_BIT(TONE_HI_BIT)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .tick_o(tick), .lo_phase_o(lo_phase), .hi_phase_o(hi_phase)
    );

    ttu_watchdog #(.N_TAPS(N_TAPS), .WD_TICKS(WD_TICKS)) u_wd (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .src_i(wd_src),
        .on_i(wd_on), .off_i(wd_off), .clr_i(wd_clr), .over_o(wd_over)
    );

    ttu_tone_out u_tone (
        .clk(clk), .rst_n(rst_n), .run_i(run), .en_i(tone_en), .hi_i(tone_hi),
        .lo_phase_i(lo_phase), .hi_phase_i(hi_phase),
        .tone_p_o(tone_p_o), .tone_n_o(tone_n_o)
    );

    // Time-base flag: clear commands beat a coincident tap firing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tb_flag_q <= 1'b0;
        else if (tb_off || wd_clr)    tb_flag_q <= 1'b0;
        else if (tb_en && tick[tb_src]) tb_flag_q <= 1'b1;
    end

    assign irq_n_o = ~(irq_en & (tb_flag_q | wd_over));

    assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_IRQ_OFF) |=> irq_n_o);

    assert_tb_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_TB_OFF) |=> !tb_flag_q);

    assert_tb_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_en && tick[tb_src] && !tb_off && !wd_clr) |=> tb_flag_q);

endmodule

// File: tb/tone_timer_unit_tb.sv
module tone_timer_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [2:0] cmd_arg = 3'd0;
    logic       tone_p, tone_n, irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tone_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_arg_i(cmd_arg), .tone_p_o(tone_p), .tone_n_o(tone_n), .irq_n_o(irq_n)
    );

    // Reference model written from the requirements
    int m_pre, m_tbsrc, m_wdsrc, m_wdcnt, m_wds;
    bit m_act, m_ton, m_hi, m_tben, m_irqen, m_tbf;

    function automatic bit fires(int pre, int k);
        return ((pre + 1) % (1 << (8 + k))) == 0;
    endfunction

    always @(posedge clk) begin : model
        bit tb_t, wd_t, v;
        if (!rst_n) begin
            m_pre <= 0; m_tbsrc <= 0; m_wdsrc <= 0; m_wdcnt <= 0; m_wds <= 0;
            m_act <= 1; m_ton <= 0; m_hi <= 0; m_tben <= 0; m_irqen <= 0; m_tbf <= 0;
        end else begin
            v    = cmd_valid;
            tb_t = m_act && fires(m_pre, m_tbsrc);
            wd_t = m_act && fires(m_pre, m_wdsrc);
            if (m_act) m_pre <= (m_pre + 1) & 32'h7FFF;
            if (v) begin
                case (cmd_op)
                    4'd1:  m_act   <= 0;
                    4'd2:  m_act   <= 1;
                    4'd3:  m_ton   <= 0;
                    4'd4:  m_ton   <= 1;
                    4'd5:  m_hi    <= 0;
                    4'd6:  m_hi    <= 1;
                    4'd7:  m_tbsrc <= int'(cmd_arg);
                    4'd8:  m_wdsrc <= int'(cmd_arg);
                    4'd9:  m_tben  <= 1;
                    4'd10: m_tben  <= 0;
                    4'd14: m_irqen <= 1;
                    4'd15: m_irqen <= 0;
                    default: ;
                endcase
            end
            if (v && (cmd_op == 4'd10 || cmd_op == 4'd13)) m_tbf <= 0;
            else if (m_tben && tb_t)                       m_tbf <= 1;
            if (v && cmd_op == 4'd12) begin
                m_wds <= 0; m_wdcnt <= 0;
            end else if (m_wds == 0) begin
                if (v && cmd_op == 4'd11) begin m_wds <= 1; m_wdcnt <= 0; end
            end else if (m_wds == 1) begin
                if (v && cmd_op == 4'd13) m_wdcnt <= 0;
                else if (wd_t) begin
                    if (m_wdcnt == 3) m_wds <= 2;
                    else              m_wdcnt <= m_wdcnt + 1;
                end
            end else begin
                if (v && cmd_op == 4'd13) begin m_wds <= 1; m_wdcnt <= 0; end
            end
        end
    end

    task automatic check(string req, bit ep, bit en, bit eq);
        n_chk++;
        if (tone_p !== ep || tone_n !== en || irq_n !== eq) begin
            n_fail++;
            $display("FAIL %s: tone_p/tone_n/irq_n got %b%b%b expected %b%b%b",
                     req, tone_p, tone_n, irq_n, ep, en, eq);
        end
    endtask

    task automatic check_model(string req);
        bit ph;
        ph = m_hi ? m_pre[5] : m_pre[6];
        check(req, m_act && m_ton && ph, m_act && m_ton && !ph,
              !(m_irqen && (m_tbf || m_wds == 2)));
    endtask

    // Called at a negedge; returns at the following negedge
    task automatic send(logic [3:0] op, logic [2:0] arg);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 4'd0; cmd_arg = 3'd0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // {op, arg, idle cycles, requirement}; R9 opcodes throughout
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {4'd0,  3'd0, 16'd3,    4'd1},  // R1 idle after reset
        {4'd4,  3'd0, 16'd40,   4'd2},  // R2 tone on
        {4'd0,  3'd0, 16'd50,   4'd3},  // R3 low pitch phase
        {4'd6,  3'd0, 16'd20,   4'd3},  // R3 high pitch
        {4'd3,  3'd0, 16'd5,    4'd2},  // R2 tone off
        {4'd14, 3'd0, 16'd2,    4'd7},  // R7 request gate on, nothing pending
        {4'd7,  3'd1, 16'd2,    4'd9},  // R9 time-base tap 1
        {4'd9,  3'd0, 16'd600,  4'd4},  // R4 flag sets within one 512 period
        {4'd13, 3'd0, 16'd2,    4'd6},  // R6 clear drops flag
        {4'd10, 3'd0, 16'd600,  4'd10}, // R10 disabled time base stays clear
        {4'd8,  3'd0, 16'd2,    4'd9},  // watchdog tap 0
        {4'd11, 3'd0, 16'd1100, 4'd5},  // R5 four firings reach overflow
        {4'd15, 3'd0, 16'd2,    4'd7},  // R7 released
        {4'd14, 3'd0, 16'd2,    4'd7},  // R7 asserted again
        {4'd12, 3'd0, 16'd2,    4'd10}, // R10 watchdog off releases
        {4'd4,  3'd0, 16'd3,    4'd2},  // tone on again
        {4'd1,  3'd0, 16'd300,  4'd8},  // R8 sleep silences tone
        {4'd2,  3'd0, 16'd70,   4'd8},  // R8 wake resumes
        {4'd5,  3'd0, 16'd33,   4'd3}   // R3 back to low pitch
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1", 1'b0, 1'b0, 1'b1);
        check_model("R1");

        for (int i = 0; i < NV; i++) begin
            logic [26:0] e;
            e = VEC[i];
            send(e[26:23], e[22:20]);
            repeat (int'(e[19:4])) @(negedge clk);
            check_model($sformatf("R%0d", e[3:0]));
        end

        // R6: clear coinciding with a tap-0 firing
        send(4'd11, 3'd0);
        while ((m_pre % 256) != 255) @(negedge clk);
        send(4'd13, 3'd0);
        repeat (868) @(negedge clk);
        check("R6 clear beats tick", tone_p, tone_n, 1'b1);
        check_model("R6");
        repeat (200) @(negedge clk);
        check("R5 fourth tick after clear", tone_p, tone_n, 1'b0);
        check_model("R5");

        // R8: watchdog frozen through a long sleep
        send(4'd12, 3'd0);
        send(4'd11, 3'd0);
        send(4'd1, 3'd0);
        repeat (5000) @(negedge clk);
        check("R8 asleep", 1'b0, 1'b0, 1'b1);
        check_model("R8");
        send(4'd2, 3'd0);
        repeat (1100) @(negedge clk);
        check("R8 resumed overflow", tone_p, tone_n, 1'b0);
        check_model("R8");
        check("R2 complement", tone_p, !tone_p, irq_n);

        finish_run();
    end

endmodule